// File: doc/BRIEF.md
# Periodic Local Interrupt Timer

This block is the countdown timer of a per-core interrupt controller. Software reaches it through a small register port. Each access is one 32-bit word, selected by a word index equal to the byte offset divided by four. The timer takes its start value from an initial-count register and counts down to zero. The count step comes from a bus clock divided by a programmable prescaler. When the count expires, the timer sends a one-cycle interrupt request that carries an 8-bit vector, unless the request is masked.

The mode word selects one of two behaviours. In periodic mode the counter reloads from the initial count after each expiry and keeps running. In one-shot mode it stops at zero after a single request. Software can read the current count at any time. Writing zero to the initial count stops the timer.

Top module: `core_tick_timer`

## Requirements
- R1: Word indices are 0xC8 (mode word), 0xE0 (initial count), 0xE4 (current count, read-only) and 0xF8 (divide code). The mode word reads back only bits [7:0] (vector), bit 16 (mask) and bit 17 (periodic), with all other bits zero. The divide register reads back only bits 3, 1 and 0. The initial count reads back as written.
- R2: After reset the mode word reads 0x00010000, which is masked, one-shot and vector 0. The initial count, current count and divide code all read zero, and there is no request.
- R3: A write to the initial count loads that value into the current count and starts counting. A write of zero leaves the current count at zero, stops the timer, and no request follows.
- R4: Divide code 0xB decrements the current count once per clock. In one-shot mode with count N, the request appears N cycles after the edge that takes the write.
- R5: The divide code bits {3,1,0}, read as a 3-bit value v, select a divide of 2^((v+1) mod 8). The prescaler runs freely, so in periodic mode with count N, consecutive requests are exactly N times the divide apart.
- R6: In periodic mode (bit 17 set), the current count reloads to the initial count at the edge that raises the request, and counting repeats without end.
- R7: In one-shot mode (bit 17 clear), exactly one request is raised per start, and the current count then holds at zero.
- R8: With the mask bit (bit 16) set, no request is raised, but the count still decrements and reloads. Clearing the mask lets requests resume.
- R9: The request lasts exactly one cycle, and irq_vector carries mode-word bits [7:0] during it.
- R10: Writes to the current-count index change neither the count nor the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the selected word |
| bus_idx | input | 8 | Word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected word (combinational) |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector that goes with the request |

## Verification
The embedded assertions check several rules on every cycle:
- A load takes the written value.
- A stopped counter stays frozen.
- A running counter moves by exactly one per prescaler tick.
- A masked request never fires.
- A one-shot request leaves the counter parked at zero.
- The prescaler never ticks on two cycles in a row at any divide other than one.

Only the bench scenarios can show the following:
- the exact cycle on which a request appears for each start value
- the spacing between requests for every divide code
- the register readback masks
- the rule that a write to the current count leaves the countdown unchanged

// File: rtl/ctt_pkg.sv
package ctt_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned IDX_W  = 8;
    localparam int unsigned PRE_W  = 7;

    localparam logic [IDX_W-1:0] IDX_MODE = 8'hC8;
    localparam logic [IDX_W-1:0] IDX_INIT = 8'hE0;
    localparam logic [IDX_W-1:0] IDX_CUR  = 8'hE4;
    localparam logic [IDX_W-1:0] IDX_DIV  = 8'hF8;

    localparam int unsigned BIT_MASK     = 16;
    localparam int unsigned BIT_PERIODIC = 17;

    typedef struct packed {
        logic       periodic;
        logic       masked;
        logic [7:0] vector;
    } mode_t;

    localparam mode_t MODE_RST = '{periodic: 1'b0, masked: 1'b1, vector: 8'h00};

    // divide code {b3,b1,b0} -> log2 of the divide ratio
    function automatic logic [2:0] div_shift(input logic [2:0] code);
        return code + 3'd1;
    endfunction

    function automatic logic [DATA_W-1:0] mode_to_word(input mode_t m);
        logic [DATA_W-1:0] w;
        w = '0;
        w[7:0]          = m.vector;
        w[BIT_MASK]     = m.masked;
        w[BIT_PERIODIC] = m.periodic;
        return w;
    endfunction
endpackage

// File: rtl/ctt_prescaler.sv
module ctt_prescaler
    import ctt_pkg::*;
#(
    parameter int unsigned W = PRE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [2:0]   shift,
    output logic         tick
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] sel;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
    end

    assign sel  = ~({W{1'b1}} << shift);
    assign tick = (cnt_q & sel) == sel;

    // R5
    tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && shift != 3'd0) |=> (!tick || shift != $past(shift)));
endmodule

// File: rtl/ctt_countdown.sv
module ctt_countdown
    import ctt_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] reload_val,
    input  logic         tick,
    input  mode_t        mode,
    output logic [W-1:0] cur,
    output logic         irq_pulse,
    output logic [7:0]   irq_vector
);
    logic running_q;
    logic expire;

    assign expire = running_q && tick && !load && (cur == W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cur        <= '0;
            running_q  <= 1'b0;
            irq_pulse  <= 1'b0;
            irq_vector <= '0;
        end else begin
            irq_pulse <= expire && !mode.masked;
            if (expire) irq_vector <= mode.vector;
            if (load) begin
                cur       <= load_val;
                running_q <= (load_val != '0);
            end else if (expire) begin
                if (mode.periodic) begin
                    cur <= reload_val;
                end else begin
                    cur       <= '0;
                    running_q <= 1'b0;
                end
            end else if (running_q && tick) begin
                cur <= cur - 1'b1;
            end
        end
    end

    // R3
    load_value_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> cur == $past(load_val));
    // R10
    stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!running_q && !load) |=> $stable(cur));
    // R4
    step_one_chk: assert property (@(posedge clk) disable iff (rst)
        (running_q && tick && !load && cur > W'(1)) |=> cur == $past(cur) - 1'b1);
    // R8
    masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> !$past(mode.masked));
    // R7
    oneshot_park_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_pulse && !$past(mode.periodic) && !$past(load)) |-> (cur == '0 && !running_q));
endmodule

// File: rtl/core_tick_timer.sv
module core_tick_timer
    import ctt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_we,
    input  logic [IDX_W-1:0]    bus_idx,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                irq_pulse,
    output logic [7:0]          irq_vector
);
    mode_t             mode_q;
    logic [2:0]        div_q;
    logic [DATA_W-1:0] init_q;
    logic [DATA_W-1:0] cur;
    logic              tick;
    logic              load;

    assign load = bus_we && (bus_idx == IDX_INIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_RST;
            div_q  <= '0;
            init_q <= '0;
        end else if (bus_we) begin
            unique case (bus_idx)
                IDX_MODE: begin
                    mode_q.vector   <= bus_wdata[7:0];
                    mode_q.masked   <= bus_wdata[BIT_MASK];
                    mode_q.periodic <= bus_wdata[BIT_PERIODIC];
                end
                IDX_INIT: init_q <= bus_wdata;
                IDX_DIV:  div_q  <= {bus_wdata[3], bus_wdata[1], bus_wdata[0]};
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (bus_idx)
            IDX_MODE: bus_rdata = mode_to_word(mode_q);
            IDX_INIT: bus_rdata = init_q;
            IDX_CUR:  bus_rdata = cur;
            IDX_DIV:  bus_rdata = {28'd0, div_q[2], 1'b0, div_q[1:0]};
            default:  bus_rdata = '0;
        endcase
    end

    ctt_prescaler #(.W(PRE_W)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .shift (div_shift(div_q)),
        .tick  (tick)
    );

    ctt_countdown #(.W(DATA_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .load_val   (bus_wdata),
        .reload_val (init_q),
        .tick       (tick),
        .mode       (mode_q),
        .cur        (cur),
        .irq_pulse  (irq_pulse),
        .irq_vector (irq_vector)
    );

    // R9
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_pulse && !mode_q.periodic) |=> !irq_pulse);
endmodule

// File: tb/core_tick_timer_tb.sv
module core_tick_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_idx = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_pulse;
    logic [7:0]  irq_vector;

    int checks = 0;
    int errs = 0;
    bit done = 1'b0;

    localparam logic [7:0] I_MODE = 8'hC8, I_INIT = 8'hE0, I_CUR = 8'hE4, I_DIV = 8'hF8;

    always #4 clk = ~clk;

    core_tick_timer dut_i (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_idx(bus_idx),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_pulse(irq_pulse), .irq_vector(irq_vector)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // enters and leaves at a negedge; consumes one posedge
    task automatic wr(input logic [7:0] i, input logic [31:0] d);
        bus_we = 1'b1; bus_idx = i; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] i, output logic [31:0] v);
        bus_idx = i;
        #1;
        v = bus_rdata;
    endtask

    function automatic logic [31:0] per_cur(input int n, input int j);
        int r;
        r = j % n;
        return (r == 0) ? n : n - r;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errs);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int pulses, first;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R2 reset state
        rd(I_MODE, v); chk("R2 mode", v, 32'h0001_0000);
        rd(I_INIT, v); chk("R2 init", v, 0);
        rd(I_CUR, v);  chk("R2 cur", v, 0);
        rd(I_DIV, v);  chk("R2 div", v, 0);
        chk("R2 irq", {31'd0, irq_pulse}, 0);

        // R1 readback masks
        wr(I_MODE, 32'hFFFF_FFFF); rd(I_MODE, v); chk("R1 mode", v, 32'h0003_00FF);
        wr(I_DIV, 32'hFFFF_FFFF);  rd(I_DIV, v);  chk("R1 div", v, 32'h0000_000B);
        wr(I_MODE, 32'h0001_0000);
        wr(I_INIT, 32'h00AB_CDEF); rd(I_INIT, v); chk("R1 init", v, 32'h00AB_CDEF);
        wr(I_INIT, 0);             rd(I_CUR, v);  chk("R3 zero stops", v, 0);

        // R10 write to current count while stopped
        wr(I_CUR, 32'h1234); rd(I_CUR, v); chk("R10 stopped", v, 0);

        // R4 R7 R9 one-shot sweep at divide-by-1
        wr(I_DIV, 32'hB);
        for (int n = 1; n <= 6; n++) begin
            wr(I_MODE, 32'h20 + n);
            wr(I_INIT, n);
            pulses = 0; first = -1;
            for (int j = 1; j <= n + 8; j++) begin
                @(negedge clk);
                if (irq_pulse) begin
                    pulses++;
                    if (first < 0) first = j;
                    chk("R9 vector", irq_vector, 32'h20 + n);
                end
                if (j == 2 && n > 2) begin rd(I_CUR, v); chk("R4 step", v, n - 2); end
            end
            chk("R4 expiry cycle", first, n);
            chk("R7 single pulse", pulses, 1);
            rd(I_CUR, v); chk("R7 parked", v, 0);
        end

        // R10 write to current count while running
        wr(I_MODE, 32'h0000_0033);
        wr(I_INIT, 20);
        repeat (3) @(negedge clk);
        rd(I_CUR, v); chk("R10 before", v, 17);
        wr(I_CUR, 0);
        rd(I_CUR, v); chk("R10 after", v, 16);

        // R3 stop by writing zero
        wr(I_INIT, 0);
        pulses = 0;
        for (int j = 0; j < 30; j++) begin @(negedge clk); if (irq_pulse) pulses++; end
        chk("R3 stopped no pulse", pulses, 0);
        rd(I_CUR, v); chk("R3 stopped cur", v, 0);

        // R6 periodic reload
        wr(I_MODE, 32'h0002_0055);
        wr(I_INIT, 4);
        for (int j = 1; j <= 20; j++) begin
            @(negedge clk);
            chk("R6 pulse timing", {31'd0, irq_pulse}, (j % 4 == 0) ? 1 : 0);
            rd(I_CUR, v); chk("R6 cur", v, per_cur(4, j));
        end
        wr(I_INIT, 0);

        // R8 mask keeps counting, no pulses
        wr(I_MODE, 32'h0003_0066);
        wr(I_INIT, 5);
        for (int j = 1; j <= 15; j++) begin
            @(negedge clk);
            chk("R8 masked pulse", {31'd0, irq_pulse}, 0);
            rd(I_CUR, v); chk("R8 masked cur", v, per_cur(5, j));
        end
        wr(I_MODE, 32'h0002_0066);
        pulses = 0;
        for (int j = 0; j < 12; j++) begin
            @(negedge clk);
            if (irq_pulse) begin pulses++; chk("R9 unmask vector", irq_vector, 32'h66); end
        end
        chk("R8 resumed", {31'd0, pulses > 0}, 1);
        wr(I_INIT, 0);

        // R5 divide sweep: gaps in periodic mode
        for (int c = 0; c < 8; c++) begin
            int d, t, cnt;
            int ts[3];
            logic [2:0] cv;
            cv = 3'(c);
            d = 1 << ((c + 1) % 8);
            wr(I_DIV, {28'd0, cv[2], 1'b0, cv[1:0]});
            wr(I_MODE, 32'h0002_0011);
            wr(I_INIT, 3);
            cnt = 0; t = 0;
            while (cnt < 3 && t < 5 * 3 * d + 20) begin
                @(negedge clk);
                t++;
                if (irq_pulse) begin ts[cnt] = t; cnt++; end
            end
            chk("R5 pulses seen", cnt, 3);
            if (cnt == 3) begin
                chk("R5 gap a", ts[1] - ts[0], 3 * d);
                chk("R5 gap b", ts[2] - ts[1], 3 * d);
            end
            wr(I_INIT, 0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end
endmodule